// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block is the decision core of an eight-input interrupt controller. It keeps three 8-bit state registers: pending requests, inputs in service, and a mask. Each input can be set to edge or level triggering. On every clock it looks for the best unmasked pending request, with priorities counted from a programmable rotation base. It raises its interrupt output only when that request outranks every input already in service, so a higher-priority source can interrupt a lower one but not the reverse.

An acknowledge strobe takes the current winner into service. An optional automatic end-of-interrupt mode clears the in-service bit again at once. In that mode the block can also move the rotation base to just past the input that was served. A specific end-of-interrupt strobe clears one in-service bit. An explicit write sets the rotation base. A build parameter chooses between a primary unit and a secondary unit. The choice fixes which trigger-mode bits can be written. On a primary unit it also lets the chained input 2 be left out of the in-service comparison. Address decoding and cascade wiring belong to the surrounding logic.

Top module: `rot_prio_irq`

## Requirements
- R1: An input whose trigger bit is 1 (level mode) has a request bit equal to that input as sampled at the previous clock edge. The request bit sets while the input is high and clears while it is low.
- R2: An input whose trigger bit is 0 (edge mode) sets its request bit only when it was low at the edge before and is high at this edge. A falling input leaves the request bit set.
- R3: Input (base + k) mod 8 has rank k, and rank 0 is the highest. An empty set of bits has rank 8. The granted input is (best pending rank + base) mod 8.
- R4: One cycle after the state registers hold a grant, `int_o` is 1 and `vec_o` is the granted input. A grant exists when the best unmasked pending rank is strictly smaller than the best in-service rank. With no grant, both outputs are 0.
- R5: `ack_i` while a grant exists sets that input's in-service bit. The request bit clears only if the input is edge-triggered. `ack_i` with no grant changes nothing.
- R6: When `auto_eoi_i` is 1 at acknowledge, the in-service bit is not kept.
- R7: When `auto_eoi_i` and `rot_aeoi_i` are both 1 at acknowledge, the base becomes (granted input + 1) mod 8. A `base_wr_i` in the same cycle wins.
- R8: On a primary unit with `nested_i` high, in-service bit 2 is left out of the in-service rank.
- R9: A trigger write stores data ANDed with 0xF8 on a primary unit, or with 0xDE on a secondary unit.
- R10: `eoi_i` clears the in-service bit selected by `eoi_idx_i`. It is applied after any acknowledge set in the same cycle.
- R11: `base_wr_i` loads `base_data_i` into the rotation base.
- R12: Reset clears every register and both outputs.
- R13: A masked input cannot produce a grant. A mask write stores `mask_data_i` in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| irq_i | input | 8 | request lines |
| trig_wr_i | input | 1 | trigger-mode write strobe |
| trig_data_i | input | 8 | trigger-mode data, 1 = level |
| mask_wr_i | input | 1 | mask write strobe |
| mask_data_i | input | 8 | mask data, 1 = masked |
| ack_i | input | 1 | acknowledge strobe |
| auto_eoi_i | input | 1 | automatic end-of-interrupt mode |
| rot_aeoi_i | input | 1 | rotate base on automatic end-of-interrupt |
| nested_i | input | 1 | ignore in-service bit 2 (primary unit only) |
| eoi_i | input | 1 | specific end-of-interrupt strobe |
| eoi_idx_i | input | 3 | in-service bit to clear |
| base_wr_i | input | 1 | rotation base write strobe |
| base_data_i | input | 3 | rotation base data |
| int_o | output | 1 | interrupt request out |
| vec_o | output | 3 | granted input index |
| req_o | output | 8 | request register |
| svc_o | output | 8 | in-service register |
| trig_o | output | 8 | trigger-mode register |
| base_o | output | 3 | rotation base |

## Verification
The assertions assume that every input is synchronous to `clk_i`, holds a known value after reset, and is sampled once per edge. They also assume that `eoi_idx_i` and `base_data_i` matter only while their strobes are high. The stimulus changes inputs only on the falling clock edge. Strobes last one cycle. The random phase flips a few request lines each cycle and mixes in acknowledges, end-of-interrupt strobes and mode bits. Even when strobes collide in one cycle, every sampled value stays defined.

// File: rtl/rot_prio_irq_pkg.sv
`timescale 1ns/1ps
package rot_prio_irq_pkg;
  localparam int unsigned NUM_IN  = 8;
  localparam int unsigned IDX_W   = $clog2(NUM_IN);
  localparam int unsigned RANK_W  = IDX_W + 1;
  localparam int unsigned CHAIN_IN = 2;
  localparam logic [NUM_IN-1:0] PRI_TRIG_MASK = 8'hF8;
  localparam logic [NUM_IN-1:0] SEC_TRIG_MASK = 8'hDE;
endpackage

// File: rtl/rpi_rank.sv
`timescale 1ns/1ps
module rpi_rank #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = 3,
  localparam int unsigned RW = IW + 1
) (
  input  logic [N-1:0]  bits_i,
  input  logic [IW-1:0] base_i,
  output logic [RW-1:0] rank_o
);
  logic [N-1:0] rot_w;

  for (genvar k = 0; k < N; k++) begin : g_rot
    assign rot_w[k] = bits_i[IW'(base_i + IW'(k))];
  end

  always_comb begin
    rank_o = RW'(N);
    for (int k = N - 1; k >= 0; k--) begin
      if (rot_w[k]) rank_o = RW'(k);
    end
  end

  always_comb begin
    if (rank_o != RW'(N)) begin
      assert_rank_hit_R3: assert (bits_i[IW'(rank_o[IW-1:0] + base_i)]);
    end else begin
      assert_rank_none_R3: assert (bits_i == '0);
    end
  end
endmodule

// File: rtl/rpi_req_reg.sv
`timescale 1ns/1ps
module rpi_req_reg #(
  parameter int unsigned N = 8,
  parameter logic [N-1:0] TRIG_MASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] irq_i,
  input  logic         trig_wr_i,
  input  logic [N-1:0] trig_data_i,
  input  logic         mask_wr_i,
  input  logic [N-1:0] mask_data_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] req_o,
  output logic [N-1:0] trig_o,
  output logic [N-1:0] mask_o
);
  logic [N-1:0] req_q, prev_q, trig_q, mask_q;
  logic [N-1:0] rise_w, req_d;

  always_comb begin
    rise_w = irq_i & ~prev_q;
    req_d  = (trig_q & irq_i) | (~trig_q & (req_q | rise_w));
    req_d  = req_d & ~(clr_i & ~trig_q);  // level sources stay asserted
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= '0;
      prev_q <= '0;
      trig_q <= '0;
      mask_q <= '0;
    end else begin
      req_q  <= req_d;
      prev_q <= irq_i;
      if (trig_wr_i) trig_q <= trig_data_i & TRIG_MASK;
      if (mask_wr_i) mask_q <= mask_data_i;
    end
  end

  assign req_o  = req_q;
  assign trig_o = trig_q;
  assign mask_o = mask_q;

  assert_level_follow_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((req_q & $past(trig_q)) == ($past(irq_i) & $past(trig_q))));

  assert_edge_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((req_q & $past(~trig_q & req_q & ~clr_i)) == $past(~trig_q & req_q & ~clr_i)));

  assert_edge_only_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((req_q & ~$past(req_q) & $past(~trig_q) & ~$past(irq_i & ~prev_q)) == '0));

  assert_trig_mask_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_q & ~TRIG_MASK) == '0);
endmodule

// File: rtl/rpi_svc_reg.sv
`timescale 1ns/1ps
module rpi_svc_reg #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ack_fire_i,
  input  logic [IW-1:0] ack_idx_i,
  input  logic          auto_eoi_i,
  input  logic          rot_aeoi_i,
  input  logic          eoi_i,
  input  logic [IW-1:0] eoi_idx_i,
  input  logic          base_wr_i,
  input  logic [IW-1:0] base_data_i,
  output logic [N-1:0]  svc_o,
  output logic [IW-1:0] base_o
);
  logic [N-1:0]  svc_q, svc_d, set_w, clr_w;
  logic [IW-1:0] base_q, base_d;

  always_comb begin
    set_w = (ack_fire_i && !auto_eoi_i) ? (N'(1) << ack_idx_i) : '0;
    clr_w = eoi_i ? (N'(1) << eoi_idx_i) : '0;
    svc_d = (svc_q | set_w) & ~clr_w;
    if (base_wr_i)                                    base_d = base_data_i;
    else if (ack_fire_i && auto_eoi_i && rot_aeoi_i)  base_d = ack_idx_i + 1'b1;
    else                                              base_d = base_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      svc_q  <= '0;
      base_q <= '0;
    end else begin
      svc_q  <= svc_d;
      base_q <= base_d;
    end
  end

  assign svc_o  = svc_q;
  assign base_o = base_q;

  assert_ack_svc_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_fire_i && !auto_eoi_i && !eoi_i) |=> svc_q[$past(ack_idx_i)]);

  assert_aeoi_keep_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_fire_i && auto_eoi_i && !eoi_i) |=> (svc_q == $past(svc_q)));

  assert_rot_base_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_fire_i && auto_eoi_i && rot_aeoi_i && !base_wr_i) |=> (base_q == IW'($past(ack_idx_i) + 1'b1)));

  assert_eoi_clr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_i |=> !svc_q[$past(eoi_idx_i)]);

  assert_base_load_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    base_wr_i |=> (base_q == $past(base_data_i)));
endmodule

// File: rtl/rot_prio_irq.sv
`timescale 1ns/1ps
module rot_prio_irq
  import rot_prio_irq_pkg::*;
#(
  parameter bit IS_MASTER = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_IN-1:0] irq_i,
  input  logic              trig_wr_i,
  input  logic [NUM_IN-1:0] trig_data_i,
  input  logic              mask_wr_i,
  input  logic [NUM_IN-1:0] mask_data_i,
  input  logic              ack_i,
  input  logic              auto_eoi_i,
  input  logic              rot_aeoi_i,
  input  logic              nested_i,
  input  logic              eoi_i,
  input  logic [IDX_W-1:0]  eoi_idx_i,
  input  logic              base_wr_i,
  input  logic [IDX_W-1:0]  base_data_i,
  output logic              int_o,
  output logic [IDX_W-1:0]  vec_o,
  output logic [NUM_IN-1:0] req_o,
  output logic [NUM_IN-1:0] svc_o,
  output logic [NUM_IN-1:0] trig_o,
  output logic [IDX_W-1:0]  base_o
);
  localparam logic [NUM_IN-1:0] TRIG_MASK = IS_MASTER ? PRI_TRIG_MASK : SEC_TRIG_MASK;

  logic [NUM_IN-1:0] req_w, trig_w, mask_w, svc_w, pend_w, svc_eff_w, clr_w;
  logic [IDX_W-1:0]  base_w, grant_idx_w;
  logic [RANK_W-1:0] pend_rank_w, svc_rank_w;
  logic              grant_w, ack_fire_w;
  logic              int_q;
  logic [IDX_W-1:0]  vec_q;

  assign pend_w = req_w & ~mask_w;

  if (IS_MASTER) begin : g_master
    always_comb begin
      svc_eff_w = svc_w;
      if (nested_i) svc_eff_w[CHAIN_IN] = 1'b0;
    end
  end else begin : g_slave
    assign svc_eff_w = svc_w;
  end

  rpi_rank #(.N(NUM_IN), .IW(IDX_W)) u_pend_rank (
    .bits_i(pend_w), .base_i(base_w), .rank_o(pend_rank_w));

  rpi_rank #(.N(NUM_IN), .IW(IDX_W)) u_svc_rank (
    .bits_i(svc_eff_w), .base_i(base_w), .rank_o(svc_rank_w));

  assign grant_w     = pend_rank_w < svc_rank_w;
  assign grant_idx_w = pend_rank_w[IDX_W-1:0] + base_w;
  assign ack_fire_w  = ack_i && grant_w;
  assign clr_w       = ack_fire_w ? (NUM_IN'(1) << grant_idx_w) : '0;

  rpi_req_reg #(.N(NUM_IN), .TRIG_MASK(TRIG_MASK)) u_req (
    .clk_i, .rst_ni, .irq_i,
    .trig_wr_i, .trig_data_i, .mask_wr_i, .mask_data_i,
    .clr_i(clr_w), .req_o(req_w), .trig_o(trig_w), .mask_o(mask_w));

  rpi_svc_reg #(.N(NUM_IN), .IW(IDX_W)) u_svc (
    .clk_i, .rst_ni,
    .ack_fire_i(ack_fire_w), .ack_idx_i(grant_idx_w),
    .auto_eoi_i, .rot_aeoi_i, .eoi_i, .eoi_idx_i,
    .base_wr_i, .base_data_i,
    .svc_o(svc_w), .base_o(base_w));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_q <= 1'b0;
      vec_q <= '0;
    end else begin
      int_q <= grant_w;
      vec_q <= grant_w ? grant_idx_w : '0;
    end
  end

  assign int_o  = int_q;
  assign vec_o  = vec_q;
  assign req_o  = req_w;
  assign svc_o  = svc_w;
  assign trig_o = trig_w;
  assign base_o = base_w;

  assert_int_pending_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_q |-> |($past(pend_w) & (NUM_IN'(1) << vec_q)));

  assert_vec_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !int_q |-> (vec_q == '0));

  assert_masked_quiet_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_q |-> !$past(mask_w[grant_idx_w]) || 1'b1 ? !(|($past(mask_w) & (NUM_IN'(1) << vec_q))) : 1'b1);

  assert_ack_nogrant_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !grant_w && !eoi_i && !base_wr_i) |=> (svc_w == $past(svc_w) && base_w == $past(base_w)));
endmodule

// File: tb/rot_prio_irq_bench.sv
`timescale 1ns/1ps
module rot_prio_irq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq = '0, trig_data = '0, mask_data = '0;
  logic       trig_wr = 0, mask_wr = 0, ack = 0, aeoi = 0, rot = 0, nested = 0;
  logic       eoi = 0, base_wr = 0;
  logic [2:0] eoi_idx = '0, base_data = '0;
  logic       int_w;
  logic [2:0] vec_w, base_w;
  logic [7:0] req_w, svc_w, trig_w;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [7:0] m_req = '0, m_prev = '0, m_trig = '0, m_mask = '0, m_svc = '0;
  logic [2:0] m_base = '0, m_vec = '0;
  logic       m_int = 0;

  always #2.5 clk = ~clk;

  rot_prio_irq u_rot_prio_irq (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq),
    .trig_wr_i(trig_wr), .trig_data_i(trig_data),
    .mask_wr_i(mask_wr), .mask_data_i(mask_data),
    .ack_i(ack), .auto_eoi_i(aeoi), .rot_aeoi_i(rot), .nested_i(nested),
    .eoi_i(eoi), .eoi_idx_i(eoi_idx), .base_wr_i(base_wr), .base_data_i(base_data),
    .int_o(int_w), .vec_o(vec_w), .req_o(req_w), .svc_o(svc_w),
    .trig_o(trig_w), .base_o(base_w));

  function automatic int rank_of(logic [7:0] b, logic [2:0] off);
    for (int k = 0; k < 8; k++) if (b[(int'(off) + k) % 8]) return k;
    return 8;
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    check("R1_R2 request", req_w, m_req);
    check("R5_R6_R10 in-service", svc_w, m_svc);
    check("R4_R8_R13 int", {7'd0, int_w}, {7'd0, m_int});
    check("R3_R4 vec", {5'd0, vec_w}, {5'd0, m_vec});
    check("R9 trig", trig_w, m_trig);
    check("R7_R11 base", {5'd0, base_w}, {5'd0, m_base});
  endtask

  // called at a falling edge with inputs set; advances one clock
  task automatic step();
    logic [7:0] pend, svc_e, rise, n_req, n_svc;
    logic [2:0] gi, n_base;
    int pr, cr;
    bit gv, fire;
    pend = m_req & ~m_mask;
    svc_e = m_svc;
    if (nested) svc_e[2] = 1'b0;
    pr = rank_of(pend, m_base);
    cr = rank_of(svc_e, m_base);
    gv = pr < cr;
    gi = 3'((pr + int'(m_base)) % 8);
    fire = ack && gv;
    rise = irq & ~m_prev;
    n_req = (m_trig & irq) | (~m_trig & (m_req | rise));
    if (fire && !m_trig[gi]) n_req[gi] = 1'b0;
    n_svc = m_svc;
    if (fire && !aeoi) n_svc[gi] = 1'b1;
    if (eoi) n_svc[eoi_idx] = 1'b0;
    n_base = m_base;
    if (base_wr) n_base = base_data;
    else if (fire && aeoi && rot) n_base = gi + 3'd1;
    @(posedge clk);
    @(negedge clk);
    m_int  = gv;
    m_vec  = gv ? gi : 3'd0;
    m_req  = n_req;
    m_prev = irq;
    if (trig_wr) m_trig = trig_data & 8'hF8;
    if (mask_wr) m_mask = mask_data;
    m_svc  = n_svc;
    m_base = n_base;
    compare_all();
    trig_wr = 0; mask_wr = 0; ack = 0; eoi = 0; base_wr = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 reset int", {7'd0, int_w}, 8'd0);
    check("R12 reset vec", {5'd0, vec_w}, 8'd0);
    check("R12 reset req", req_w, 8'd0);
    check("R12 reset svc", svc_w, 8'd0);
    check("R12 reset trig/base", trig_w | {5'd0, base_w}, 8'd0);
    rst_n = 1'b1;

    // R3 rank from base 0, then base 5
    irq = 8'h42; step(); step();
    check("R3 base0 grant", {5'd0, vec_w}, 8'd1);
    base_wr = 1; base_data = 3'd5; step(); step();
    check("R11 base5 grant", {5'd0, vec_w}, 8'd6);
    ack = 1; step();
    check("R5 ack into service", svc_w, 8'h40);
    step();
    check("R4 lower rank blocked", {7'd0, int_w}, 8'd0);
    eoi = 1; eoi_idx = 3'd6; step(); step();
    check("R10 eoi releases", {5'd0, vec_w}, 8'd1);
    ack = 1; aeoi = 1; rot = 1; step();
    check("R7 rotate base", {5'd0, base_w}, 8'd2);
    check("R6 auto eoi svc", svc_w, 8'h00);
    aeoi = 0; rot = 0;

    // R8 nested mode ignores in-service bit 2
    irq = 8'h04; step(); step();
    ack = 1; step();
    irq = 8'h24; step(); step();
    check("R8 nested off blocks", {7'd0, int_w}, 8'd0);
    nested = 1; step();
    check("R8 nested on grants", {5'd0, vec_w}, 8'd5);
    nested = 0; eoi = 1; eoi_idx = 3'd2; step();

    // R9 masked trigger write, R1 level behaviour, R2 falling edge
    trig_wr = 1; trig_data = 8'hFF; step();
    check("R9 trig mask", trig_w, 8'hF8);
    irq = 8'h0C; step();
    check("R1 level follows high", req_w, 8'h08);
    irq = 8'h04; step();
    check("R1 level follows low", req_w, 8'h00);
    trig_wr = 1; trig_data = 8'h00; step();
    irq = 8'h05; step();
    irq = 8'h00; step();
    check("R2 falling keeps", req_w, 8'h01);

    // R13 mask
    mask_wr = 1; mask_data = 8'h01; step(); step();
    check("R13 masked quiet", {7'd0, int_w}, 8'd0);
    mask_wr = 1; mask_data = 8'h00; step(); step();
    check("R13 unmasked grant", {6'd0, vec_w == 3'd0, int_w}, 8'd3);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      irq = irq ^ 8'($urandom & $urandom & $urandom);
      if ($urandom % 32 == 0) begin trig_wr = 1; trig_data = 8'($urandom); end
      if ($urandom % 16 == 0) begin mask_wr = 1; mask_data = 8'($urandom & $urandom); end
      ack    = ($urandom % 4 == 0);
      aeoi   = ($urandom % 3 == 0);
      rot    = 1'($urandom);
      nested = ($urandom % 4 == 0);
      if ($urandom % 5 == 0) begin eoi = 1; eoi_idx = 3'($urandom); end
      if ($urandom % 32 == 0) begin base_wr = 1; base_data = 3'($urandom); end
      step();
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule